// File: doc/BRIEF.md
# Glitchless Power-of-Two Clock Prescaler

This block takes a free-running master clock and produces an output clock at the master rate divided by 2^x, where x is a 4-bit select between 0 and 8. The output goes to a tristate pad, so the block drives two signals: the output data and a drive enable. When the output is not producing pulses, a single idle-mode bit chooses how the pin rests. With the bit set, the pin is driven low. With the bit clear, the pin floats.

The output produces pulses only when three conditions hold: the output-enable input is high, the oscillator is awake, and the start-up hold-off has run out. The hold-off lasts 512 master edges and applies after reset and after each wake from power-down. An active-low power-down input has to stay low for two full output periods before it takes effect. Power-down holds the divider still, which models a stopped oscillator. Enable, disable, divide changes and power-down entry are all timed so that every high phase on the pin has its full length.

The inputs are treated as synchronous to the master clock. A divide-by-1 setting passes the master clock through a gate that only opens or closes while the master clock is low.

Top module: `pow2_clk_prescaler`

## Requirements
- R1: For a divide select x from 1 to 8, the running output is high for 2^(x-1) master cycles and then low for 2^(x-1) master cycles.
- R2: A divide select of 9 to 15 behaves exactly as 8, giving 128 cycles high and 128 cycles low.
- R3: A divide select of 0 makes the running output follow the master clock: high while the master clock is high and low while it is low.
- R4: The output stays low during two windows: the first 512 rising master edges after reset release, and the first 512 rising master edges after pdn_n returns high from power-down. Pulses begin within one output period after the window ends.
- R5: While oe is low, no new high phase begins, and the output settles low within one output period. When oe returns high, pulses resume.
- R6: Toggling oe at any time never produces a shortened high phase. Every high phase lasts exactly 2^(x-1) master cycles.
- R7: A new divide select is applied only at a cycle where the whole divider chain is low. Every high phase is therefore either the old full length or the new full length.
- R8: While no pulses are driven, drive_en equals idle_low and clk_out is 0. In other words, idle_low=1 holds the pin low, and idle_low=0 releases it to high impedance. This holds in reset too.
- R9: A low on pdn_n that lasts fewer than 2^(x+1) consecutive master edges is ignored. The output carries on without a new hold-off.
- R10: A low on pdn_n that lasts 2^(x+1) master edges powers the block down once the output is low. The divider stops and the output stays off for as long as pdn_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| oe | input | 1 | Output enable, high lets pulses reach the pin |
| pdn_n | input | 1 | Power-down request, active low, filtered |
| div_sel | input | SEL_W | Divide exponent x; values above MAX_EXP clamp |
| idle_low | input | 1 | Idle pin mode: 1 drives low, 0 floats |
| clk_out | output | 1 | Output clock data to the pad |
| drive_en | output | 1 | Pad drive enable (0 = high impedance) |

## Verification
The bench builds the block with its default parameters:
- MAX_EXP = 8, so the 256-cycle clamp case is in range.
- A 4-bit select, so codes 9 to 15 can exercise the clamp.
- A 512-edge hold-off, so the real start-up and wake windows are measured edge by edge.

Divide settings 2 and 3 are used for the power-down filter and the enable tests. Their 8- and 16-edge filter windows let the test place a 7-edge pulse just under the limit and a long pulse well over it, each within a few dozen cycles.

// File: rtl/pow2_presc_pkg.sv
`timescale 1ns/1ps
package pow2_presc_pkg;

    // Oscillator life-cycle: hold-off, running, stopped
    typedef enum logic [1:0] {
        PW_START = 2'd0,
        PW_RUN   = 2'd1,
        PW_DOWN  = 2'd2
    } pw_state_e;

endpackage

// File: rtl/presc_div_core.sv
`timescale 1ns/1ps
module presc_div_core #(
    parameter int MAX_EXP = 8,
    parameter int SEL_W   = 4,
    parameter int EXP_W   = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_on_d,
    input  logic [SEL_W-1:0] div_sel,
    output logic [EXP_W-1:0] exp_q,
    output logic [EXP_W-1:0] exp_d,
    output logic             tap_now,
    output logic             tap_next
);

    localparam int CNT_W = MAX_EXP;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] xp;
    } core_t;

    core_t d, q;
    logic [EXP_W-1:0] sel_clamped;

    function automatic logic pick_tap(input logic [CNT_W-1:0] c,
                                      input logic [EXP_W-1:0] e);
        logic [CNT_W-1:0] sh;
        sh = c >> (e - 1'b1);
        return (e == '0) ? 1'b0 : sh[0];
    endfunction

    always_comb begin
        sel_clamped = (div_sel > SEL_W'(MAX_EXP)) ? EXP_W'(MAX_EXP)
                                                  : EXP_W'(div_sel);
        d     = q;
        d.cnt = osc_on_d ? q.cnt + 1'b1 : '0;
        // switch exponent only when every divider stage is low
        d.xp  = (d.cnt == '0) ? sel_clamped : q.xp;
        tap_now  = pick_tap(q.cnt, q.xp);
        tap_next = pick_tap(d.cnt, d.xp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign exp_q = q.xp;
    assign exp_d = d.xp;

    AST_EXP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xp != $past(q.xp)) |-> (q.cnt == '0)); // R7

endmodule

// File: rtl/presc_pwr_ctl.sv
`timescale 1ns/1ps
module presc_pwr_ctl
    import pow2_presc_pkg::*;
#(
    parameter int MAX_EXP   = 8,
    parameter int START_CYC = 512,
    parameter int EXP_W     = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_n,
    input  logic [EXP_W-1:0] exp_q,
    input  logic             tap_now,
    output logic             osc_on_d,
    output logic             running
);

    localparam int ST_W = $clog2(START_CYC);
    localparam int PD_W = MAX_EXP + 2;

    typedef struct packed {
        pw_state_e        state;
        logic [ST_W-1:0]  st_cnt;
        logic [PD_W-1:0]  pd_cnt;
    } pwr_t;

    pwr_t d, q;
    logic [PD_W-1:0] pd_limit;

    always_comb begin
        pd_limit = PD_W'(2) << exp_q;   // two output periods
        d = q;
        if (q.state == PW_DOWN) begin
            d.pd_cnt = '0;
            if (pdn_n) begin
                d.state  = PW_START;
                d.st_cnt = '0;
            end
        end else begin
            if (!pdn_n) begin
                if (q.pd_cnt < pd_limit - 1'b1) begin
                    d.pd_cnt = q.pd_cnt + 1'b1;
                end else if (!tap_now) begin
                    d.state  = PW_DOWN;
                    d.pd_cnt = '0;
                end
            end else begin
                d.pd_cnt = '0;
            end
            if (q.state == PW_START && d.state != PW_DOWN) begin
                if (q.st_cnt == ST_W'(START_CYC - 1)) d.state  = PW_RUN;
                else                                  d.st_cnt = q.st_cnt + 1'b1;
            end
        end
        osc_on_d = (d.state != PW_DOWN);
        running  = (q.state == PW_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: PW_START, st_cnt: '0, pd_cnt: '0};
        else        q <= d;
    end

    AST_RUN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PW_RUN && $past(q.state) == PW_START)
            |-> ($past(q.st_cnt) == ST_W'(START_CYC - 1))); // R4

    AST_PD_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == PW_DOWN && $past(q.state) != PW_DOWN)
            |-> ($past(q.pd_cnt) >= $past(pd_limit) - 1'b1)); // R10

    AST_NO_PD_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_n |=> (q.state != PW_DOWN)); // R9

endmodule

// File: rtl/presc_out_gate.sv
`timescale 1ns/1ps
module presc_out_gate #(
    parameter int MAX_EXP = 8,
    parameter int EXP_W   = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic [EXP_W-1:0] exp_q,
    input  logic [EXP_W-1:0] exp_d,
    input  logic             tap_now,
    input  logic             tap_next,
    input  logic             idle_low,
    output logic             clk_out,
    output logic             drive_en,
    output logic             div_out_q
);

    typedef struct packed {
        logic gate;
        logic outv;
    } gate_t;

    gate_t d, q;
    logic  byp_gate_q;

    always_comb begin
        d = q;
        // gate may change only while the divided output is low
        if (!tap_now) d.gate = want && (exp_d != '0);
        d.outv = d.gate & tap_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // divide-by-1 gate moves only while the master clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_gate_q <= 1'b0;
        else        byp_gate_q <= want && (exp_q == '0);
    end

    assign clk_out   = (clk & byp_gate_q) | q.outv;
    assign drive_en  = byp_gate_q | q.gate | idle_low;
    assign div_out_q = q.outv;

    AST_RISE_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.outv) |-> $rose(tap_now)); // R6

    AST_FALL_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.outv) |-> !tap_now); // R6

    AST_GATE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.gate) |-> !q.outv); // R5

endmodule

// File: rtl/pow2_clk_prescaler.sv
`timescale 1ns/1ps
module pow2_clk_prescaler #(
    parameter int MAX_EXP   = 8,
    parameter int SEL_W     = 4,
    parameter int START_CYC = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe,
    input  logic             pdn_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             idle_low,
    output logic             clk_out,
    output logic             drive_en
);

    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [EXP_W-1:0] exp_q, exp_d;
    logic             tap_now, tap_next;
    logic             osc_on_d, running, want, div_out_q;

    assign want = oe & running;

    presc_div_core #(.MAX_EXP(MAX_EXP), .SEL_W(SEL_W), .EXP_W(EXP_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_on_d (osc_on_d),
        .div_sel  (div_sel),
        .exp_q    (exp_q),
        .exp_d    (exp_d),
        .tap_now  (tap_now),
        .tap_next (tap_next)
    );

    presc_pwr_ctl #(.MAX_EXP(MAX_EXP), .START_CYC(START_CYC), .EXP_W(EXP_W)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_n    (pdn_n),
        .exp_q    (exp_q),
        .tap_now  (tap_now),
        .osc_on_d (osc_on_d),
        .running  (running)
    );

    presc_out_gate #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .exp_q     (exp_q),
        .exp_d     (exp_d),
        .tap_now   (tap_now),
        .tap_next  (tap_next),
        .idle_low  (idle_low),
        .clk_out   (clk_out),
        .drive_en  (drive_en),
        .div_out_q (div_out_q)
    );

    AST_QUIET_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !div_out_q); // R4

endmodule

// File: tb/pow2_clk_prescaler_tb.sv
`timescale 1ns/1ps
module pow2_clk_prescaler_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe = 1'b1;
    logic       pdn_n = 1'b1;
    logic       idle_low = 1'b1;
    logic [3:0] div_sel = 4'd1;
    logic       clk_out, drive_en;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pow2_clk_prescaler u_dut (
        .clk(clk), .rst_n(rst_n), .oe(oe), .pdn_n(pdn_n),
        .div_sel(div_sel), .idle_low(idle_low),
        .clk_out(clk_out), .drive_en(drive_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic measure(output int hi, output int lo);
        int g = 0;
        while (clk_out && g < 3000)  begin step(); g++; end
        while (!clk_out && g < 3000) begin step(); g++; end
        hi = 0; lo = 0;
        while (clk_out && g < 3000)  begin step(); g++; hi++; end
        while (!clk_out && g < 3000) begin step(); g++; lo++; end
    endtask

    task automatic settle(input logic [3:0] sel);
        div_sel = sel;
        repeat (600) step();
    endtask

    // R4 / R8: reset state and start-up hold-off
    task automatic t_reset();
        int first = 0;
        repeat (3) step();
        chk(drive_en == 1'b1 && clk_out == 1'b0, "R8", "reset pin state",
            {drive_en, clk_out}, 2);
        rst_n = 1'b1;
        while (!clk_out && first < 700) begin step(); first++; end
        chk(first >= 513 && first <= 515, "R4", "first high edge after reset", first, 513);
    endtask

    // R1: output shape for several exponents
    task automatic t_divide(input int x);
        int hi, lo;
        settle(4'(x));
        measure(hi, lo);
        chk(hi == (1 << (x-1)) && lo == (1 << (x-1)), "R1", "high length",
            hi, 1 << (x-1));
    endtask

    // R2: codes above 8 clamp
    task automatic t_clamp();
        int hi, lo;
        settle(4'd13);
        measure(hi, lo);
        chk(hi == 128 && lo == 128, "R2", "clamped high/low", hi + lo, 256);
    endtask

    // R3: divide-by-1 follows master clock
    task automatic t_bypass();
        int errs = 0;
        settle(4'd0);
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #(CLK_P/4);
            if (clk_out !== 1'b1) errs++;
            @(negedge clk); #(CLK_P/4);
            if (clk_out !== 1'b0) errs++;
        end
        chk(errs == 0, "R3", "bypass mismatches", errs, 0);
    endtask

    // R5: oe gating
    task automatic t_oe();
        int highs = 0, seen = 0;
        settle(4'd3);
        oe = 1'b0;
        repeat (8) step();
        for (int i = 0; i < 40; i++) begin step(); if (clk_out) highs++; end
        chk(highs == 0, "R5", "highs while oe low", highs, 0);
        oe = 1'b1;
        while (!clk_out && seen < 20) begin step(); seen++; end
        chk(seen <= 9, "R5", "cycles to resume", seen, 9);
    endtask

    // R6: random-ish oe toggling leaves only full high phases
    task automatic t_glitch();
        int run = 0, bad = 0, runs = 0;
        bit prev = 1'b0;
        div_sel = 4'd3;
        while (clk_out) step();
        for (int i = 0; i < 400; i++) begin
            if (i % 7 == 3 || i % 11 == 5) oe = ~oe;
            step();
            if (clk_out) run++;
            else begin
                if (prev) begin runs++; if (run != 4) bad++; end
                run = 0;
            end
            prev = clk_out;
        end
        oe = 1'b1;
        chk(bad == 0, "R6", "shortened high phases", bad, 0);
        chk(runs > 5, "R6", "high phases observed", runs, 6);
    endtask

    // R7: divide change only ever shows old or new full length
    task automatic t_change();
        int run = 0, bad = 0, last = 0, n2 = 0;
        bit prev = 1'b0;
        settle(4'd2);
        while (clk_out) step();
        div_sel = 4'd5;
        for (int i = 0; i < 800; i++) begin
            step();
            if (clk_out) run++;
            else begin
                if (prev) begin
                    if (run != 2 && run != 16) bad++;
                    if (run == 2) n2++;
                    last = run;
                end
                run = 0;
            end
            prev = clk_out;
        end
        chk(bad == 0, "R7", "odd high lengths", bad, 0);
        chk(last == 16 && n2 > 0, "R7", "final high length", last, 16);
    endtask

    // R8: idle pin behaviour
    task automatic t_idle();
        div_sel = 4'd3;
        oe = 1'b0;
        repeat (300) step();
        idle_low = 1'b0; step();
        chk(drive_en == 1'b0, "R8", "float drive_en", drive_en, 0);
        idle_low = 1'b1; step();
        chk(drive_en == 1'b1 && clk_out == 1'b0, "R8", "low drive", {drive_en, clk_out}, 2);
        oe = 1'b1;
    endtask

    // R9: short power-down pulse ignored
    task automatic t_pd_short();
        int seen = 0;
        settle(4'd2);
        pdn_n = 1'b0;
        repeat (7) step();
        pdn_n = 1'b1;
        while (!clk_out && seen < 40) begin step(); seen++; end
        chk(seen <= 6, "R9", "cycles to next high", seen, 6);
    endtask

    // R10 and R4 wake hold-off
    task automatic t_pd_long();
        int highs = 0, early = 0, first = 0;
        settle(4'd2);
        pdn_n = 1'b0;
        repeat (12) step();
        for (int i = 0; i < 60; i++) begin step(); if (clk_out) highs++; end
        chk(highs == 0, "R10", "highs in power-down", highs, 0);
        pdn_n = 1'b1;
        while (!clk_out && first < 700) begin step(); first++; end
        if (first < 510) early = 1;
        chk(early == 0, "R4", "wake hold-off length", first, 514);
        chk(first <= 530, "R4", "wake resume", first, 514);
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_divide(1);
        t_divide(3);
        t_divide(5);
        t_divide(8);
        t_clamp();
        t_bypass();
        t_oe();
        t_glitch();
        t_change();
        t_idle();
        t_pd_short();
        t_pd_long();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule